// File: doc/BRIEF.md
# Bus-Attached Pin Expander with Edge Interrupt Flags

This block adds input pins, interrupt sources and output pins to a host through a small synchronous register port: chip select, halfword address, write enable, write data and read data. Three halfword registers are decoded. The status register at offset 0 shows the synchronized levels of the general inputs in its low byte. Its high byte holds one pending flag for each of the eight interrupt sources. Offsets 1 and 2 hold output words that drive the output pins.

A flag latches when its source shows a rising edge after synchronization. No mask exists inside the block, so every edge on every source is recorded. The host clears flags by writing the status register: each flag whose write-data bit is 0 is cleared and each flag whose bit is 1 is kept, so a write of zero clears them all. The single host interrupt line is the OR of all pending flags. When it drops and a later event raises it again, the host sees a new rising edge, which suits edge-triggered sensing.

Top module: `gpio_xpndr`

## Requirements
- R1: After reset all flags are clear, the output word at offset 1 is 0x0000, the output word at offset 2 is 0x0100 (out_pins = 0x0100_0000), and host_irq is low.
- R2: A read of offset 0 returns the general input levels in bits 7:0, after a two-flop synchronizer, so a change shows in the third cycle after it is applied.
- R3: A flag latches on a synchronized rising edge of its source, and source i appears at bit i+8 of offset 0. A source that is held high does not set its flag again after the flag is cleared.
- R4: A write to offset 0 clears each flag whose data bit (15:8) is 0 and keeps each flag whose data bit is 1. Bits 7:0 of that write have no effect.
- R5: Writing 0x0000 to offset 0 clears every pending flag.
- R6: There is no mask: all eight sources set their flags.
- R7: host_irq is high exactly while at least one flag is pending. It falls when all flags are cleared and rises again on a new event.
- R8: If a rising edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Writes to offsets 1 and 2 replace the whole word. out_pins[15:0] carries offset 1 and out_pins[31:16] carries offset 2, and reads of those offsets return the last value written.
- R10: Offset 3 reads as 0x0000. A write to it changes no output and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Halfword offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the read cycle, zero otherwise |
| lvl_in | input | 8 | General input pins |
| irq_src | input | 8 | Interrupt source pins |
| out_pins | output | 32 | Output words: offset 1 in bits 15:0, offset 2 in bits 31:16 |
| host_irq | output | 1 | Interrupt to host, OR of pending flags |

## Verification
The bench builds the block with its defaults: 16-bit words, eight sources, two output words, a 2-bit offset and two synchronizer stages. With a 2-bit offset, offset 3 exists as an unmapped hole, so the ignore-and-read-zero behaviour can be reached. Because the synchronizer is exactly two stages deep, the bench can place a clearing write in the very cycle a source edge is detected and confirm that the set wins. Sources held high across a clear show that flags follow edges and not levels.

// File: rtl/gx_pkg.sv
package gx_pkg;

    typedef enum logic [1:0] {
        RGN_STAT = 2'd0,
        RGN_OUT  = 2'd1,
        RGN_NONE = 2'd2
    } gx_rgn_e;

    // Map a halfword offset onto the region it selects.
    function automatic gx_rgn_e gx_region(input int unsigned off, input int unsigned n_out);
        if (off == 0)          return RGN_STAT;
        else if (off <= n_out) return RGN_OUT;
        else                   return RGN_NONE;
    endfunction

endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.pipe[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/gx_flags.sv
module gx_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_s,
    input  logic         clr_en,
    input  logic [N-1:0] clr_keep,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] rise,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        rise      = src_s & ~st_q.prev;
        st_d.prev = src_s;
        // The edge is ORed in after the clear, so a set in the same cycle wins.
        st_d.flag = (clr_en ? (st_q.flag & clr_keep) : st_q.flag) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;
    assign irq    = |st_q.flag;
endmodule

// File: rtl/gx_outregs.sv
module gx_outregs #(
    parameter int                        DATA_W  = 16,
    parameter int                        NUM_OUT = 2,
    parameter int                        ADDR_W  = 2,
    parameter logic [NUM_OUT*DATA_W-1:0] OUT_RST = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_OUT*DATA_W-1:0] regs
);
    typedef struct packed {
        logic [NUM_OUT-1:0][DATA_W-1:0] word;
    } out_st_t;

    out_st_t            st_d, st_q;
    logic [NUM_OUT-1:0] hit;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_word
        assign hit[g] = wr_en && (int'(wr_idx) == g);
        always_comb begin
            st_d.word[g] = hit[g] ? wr_data : st_q.word[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OUT_RST;
        else        st_q <= st_d;
    end

    assign regs = st_q;
endmodule

// File: rtl/gpio_xpndr.sv
module gpio_xpndr #(
    parameter int                        DATA_W      = 16,
    parameter int                        NUM_SRC     = 8,
    parameter int                        NUM_OUT     = 2,
    parameter int                        ADDR_W      = 2,
    parameter int                        SYNC_STAGES = 2,
    parameter logic [NUM_OUT*DATA_W-1:0] OUT_RST     = 32'h0100_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [DATA_W-NUM_SRC-1:0] lvl_in,
    input  logic [NUM_SRC-1:0]        irq_src,
    output logic [NUM_OUT*DATA_W-1:0] out_pins,
    output logic                      host_irq
);
    import gx_pkg::*;

    localparam int LVL_W = DATA_W - NUM_SRC;

    logic [LVL_W-1:0]   lvl_s;
    logic [NUM_SRC-1:0] src_s;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] src_rise;
    logic [ADDR_W-1:0]  out_idx;
    gx_rgn_e            rgn;

    assign rgn     = gx_region(int'(bus_addr), NUM_OUT);
    assign out_idx = bus_addr - ADDR_W'(1);

    gx_sync #(.W(LVL_W + NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({irq_src, lvl_in}),
        .dout ({src_s, lvl_s})
    );

    gx_flags #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_s   (src_s),
        .clr_en  (bus_sel && bus_we && (rgn == RGN_STAT)),
        .clr_keep(bus_wdata[DATA_W-1:LVL_W]),
        .flag_q  (flag_q),
        .rise    (src_rise),
        .irq     (host_irq)
    );

    gx_outregs #(
        .DATA_W (DATA_W),
        .NUM_OUT(NUM_OUT),
        .ADDR_W (ADDR_W),
        .OUT_RST(OUT_RST)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_sel && bus_we && (rgn == RGN_OUT)),
        .wr_idx (out_idx),
        .wr_data(bus_wdata),
        .regs   (out_pins)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (rgn)
                RGN_STAT: bus_rdata = {flag_q, lvl_s};
                RGN_OUT:  bus_rdata = out_pins[int'(out_idx)*DATA_W +: DATA_W];
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gx_chk.sv
module gx_chk #(
    parameter int                        DATA_W  = 16,
    parameter int                        NUM_SRC = 8,
    parameter int                        NUM_OUT = 2,
    parameter int                        ADDR_W  = 2,
    parameter logic [NUM_OUT*DATA_W-1:0] OUT_RST = '0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_sel,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [NUM_OUT*DATA_W-1:0] out_pins,
    input logic                      host_irq,
    input logic [NUM_SRC-1:0]        flag_q,
    input logic [NUM_SRC-1:0]        src_rise
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (out_pins == OUT_RST && flag_q == '0));

    // R3
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_rise) |=> ((flag_q & $past(src_rise)) == $past(src_rise)));

    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q & ~$past(flag_q) & ~$past(src_rise)) == '0);

    // R4
    clear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == '0) |=>
        ((flag_q & ~$past(src_rise)) ==
         ($past(flag_q) & $past(bus_wdata[DATA_W-1:DATA_W-NUM_SRC]) & ~$past(src_rise))));

    // R7
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0 && src_rise == '0) |=> !host_irq);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !(bus_sel && bus_we && bus_addr == '0)) |=> host_irq);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> $stable(out_pins));

    // R10
    hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && int'(bus_addr) > NUM_OUT) |-> bus_rdata == '0);
endmodule

bind gpio_xpndr gx_chk #(
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC),
    .NUM_OUT(NUM_OUT),
    .ADDR_W (ADDR_W),
    .OUT_RST(OUT_RST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .out_pins (out_pins),
    .host_irq (host_irq),
    .flag_q   (flag_q),
    .src_rise (src_rise)
);

// File: tb/gpio_xpndr_bench.sv
module gpio_xpndr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  lvl_in = '0;
    logic [7:0]  irq_src = '0;
    logic [31:0] out_pins;
    logic        host_irq;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_xpndr u_gpio_xpndr (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lvl_in   (lvl_in),
        .irq_src  (irq_src),
        .out_pins (out_pins),
        .host_irq (host_irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Driver: pushes the expected read value, then issues the read.
    task automatic bus_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        @(posedge clk); #1;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    // Monitor: compares read data against the scoreboard mid-cycle.
    always @(negedge clk) begin
        if (bus_sel && !bus_we) begin
            if (sb_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL unexpected read actual=0x%04h expected=none", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk({16'h0, bus_rdata}, {16'h0, it.exp}, it.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk({31'h0, host_irq}, 32'h0, "R1 irq after reset");
        chk(out_pins, 32'h0100_0000, "R1 out_pins after reset");
        bus_rd(2'd0, 16'h0000, "R1 status after reset");
        bus_rd(2'd1, 16'h0000, "R1 word1 after reset");
        bus_rd(2'd2, 16'h0100, "R1 word2 after reset");

        // R2 input levels through synchronizer
        lvl_in = 8'hA5; idle(3);
        bus_rd(2'd0, 16'h00A5, "R2 levels A5");
        lvl_in = 8'h3C; idle(3);
        bus_rd(2'd0, 16'h003C, "R2 levels 3C");

        // R3 single source edge, R7 irq rises
        irq_src[2] = 1'b1; idle(4);
        chk({31'h0, host_irq}, 32'h1, "R7 irq on first event");
        bus_rd(2'd0, 16'h043C, "R3 source 2 at bit 10");

        // R6 all sources set, no mask
        irq_src = 8'hFF; idle(4);
        bus_rd(2'd0, 16'hFF3C, "R6 all flags set");

        // R4 selective clear, low byte ignored
        bus_wr(2'd0, 16'hF0FF);
        bus_rd(2'd0, 16'hF03C, "R4 clear low nibble keep high");
        chk({31'h0, host_irq}, 32'h1, "R7 irq held while pending");

        // R5 clear all
        bus_wr(2'd0, 16'h0000);
        bus_rd(2'd0, 16'h003C, "R5 zero write clears all");
        chk({31'h0, host_irq}, 32'h0, "R7 irq low when clear");
        idle(4);
        bus_rd(2'd0, 16'h003C, "R3 held-high source does not re-set");

        // R7 fresh event after clear
        irq_src = 8'h00; idle(4);
        chk({31'h0, host_irq}, 32'h0, "R7 falling source sets nothing");
        irq_src[5] = 1'b1; idle(4);
        chk({31'h0, host_irq}, 32'h1, "R7 irq rises again");
        bus_rd(2'd0, 16'h203C, "R3 source 5 at bit 13");

        // R8 set wins over clear in the same cycle
        bus_wr(2'd0, 16'h0000);
        idle(1);
        @(posedge clk); #1;
        irq_src[6] = 1'b1;
        @(posedge clk); #1;
        bus_wr(2'd0, 16'h0000);
        bus_rd(2'd0, 16'h403C, "R8 set beats clear");

        // R9 output words
        bus_wr(2'd1, 16'h1234);
        bus_wr(2'd2, 16'hBEEF);
        chk(out_pins, 32'hBEEF_1234, "R9 out_pins after writes");
        bus_rd(2'd1, 16'h1234, "R9 word1 readback");
        bus_rd(2'd2, 16'hBEEF, "R9 word2 readback");

        // R10 unmapped offset
        bus_wr(2'd3, 16'hFFFF);
        chk(out_pins, 32'hBEEF_1234, "R10 hole write leaves outputs");
        bus_rd(2'd3, 16'h0000, "R10 hole reads zero");
        bus_rd(2'd0, 16'h403C, "R10 hole write leaves flags");

        idle(3);
        if (sb_q.size() != 0) begin
            tests++; fails++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule